// File: doc/BRIEF.md
# March C+ Memory Self-Test Controller with Serial Diagnosis

This controller tests a single-port synchronous SRAM by running a six-element March C+ sequence. It drives the address, the write data and the read/write command for every operation. It compares each read word against the value that should be stored there. The inner elements visit each address with a read, a write and a read before they step to the next address. A measurement-enable strobe marks the read that follows each write, so an access-time sensor can sample alongside the test in a regular one-in-three-cycle window.

In normal mode the controller runs to the end and reports a sticky fail flag and a done flag. In diagnosis mode it halts the sequence at every mismatch. It then shifts out a serial record built from three fields: a 5-bit operation code, the failing address, and the XOR of the read word with the expected word. After the last bit it resumes with the operation that was held back. Every failure is reported in this way, not only the first one.

Top module: `mbist_marchcp`

## Requirements
- R1: After reset the outputs busy, done, fail, mem_en, meas_en and scan_valid are all 0.
- R2: After start, the operations issued are, in order: element 0 writes 0 to addresses 0..N-1 in ascending order. Elements 1 and 2 visit addresses 0..N-1 in ascending order. Elements 3 and 4 visit N-1..0 in descending order. At each address, element 1 and element 3 issue (R0,W1,R1), and element 2 and element 4 issue (R1,W0,R0). Element 5 reads 0 from each address in ascending order. N = 2^AW, so 14N operations are issued in total.
- R3: A write of value 1 drives all ones on mem_wdata, and a write of value 0 drives all zeros. A read is checked against mem_rdata in the cycle that follows its command.
- R4: meas_en is 1 exactly in the cycles that issue the third operation (position 2, a read) of elements 1 to 4.
- R5: fail becomes 1 when any read mismatches and stays 1 until the next start. In normal mode (diag_mode=0 at start) scan_valid never rises.
- R6: done rises busy-cycle 14N+2 after start on a clean run (busy high for exactly 14N+2 cycles). done then holds until a new start.
- R7: In diagnosis mode each mismatch produces one record of 5+AW+DW bits, shifted MSB first on scan_out while scan_valid is 1. The record fields, from the MSB down, are: element index (3 bits), position 0..2 within the element (2 bits), address, and signature = read data XOR expected data.
- R8: No memory operation is issued while a record is shifted. The sequence then resumes at the held operation, so the full 14N-operation order of R2 is kept and every failing read yields a record.
- R9: A new start after done clears fail and runs the test again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a test when idle or done |
| diag_mode | input | 1 | Sampled at start; 1 selects diagnosis mode |
| mem_en | output | 1 | Memory command valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read |
| meas_en | output | 1 | Access-time measurement window |
| scan_out | output | 1 | Serial error record bit |
| scan_valid | output | 1 | scan_out carries a record bit |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished |
| fail | output | 1 | Sticky mismatch flag |

## Verification
The bench checks every issued operation against an order computed separately from the element rules. A controller that turned the wrong way in a descending element, or that repeated or skipped the held operation after a scan, fails this check. Stuck-at-1 and stuck-at-0 cells at an interior address and at address 0 (the last address of the descending elements) must each produce a record set with exactly the expected operation codes and signatures. An off-by-one in the compare pipeline would give wrong signatures or spurious failures. An error in the record length or the bit order would corrupt the decoded fields. The strobe count and the busy length catch a misplaced measurement window and a done flag that comes early or late.

// File: rtl/mbist_marchcp.sv
module mbist_marchcp #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          diag_mode,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          meas_en,
  output logic          scan_out,
  output logic          scan_valid,
  output logic          busy,
  output logic          done,
  output logic          fail
);
  localparam int RL = 5 + AW + DW;
  localparam int CW = $clog2(RL + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_SCAN, S_DONE} st_t;
  st_t st;

  logic [2:0]    elem;
  logic [1:0]    pos;
  logic [AW-1:0] addr;
  logic          seq_end, diag_q;
  logic          chk_valid;
  logic [DW-1:0] chk_exp;
  logic [4:0]    chk_op;
  logic [AW-1:0] chk_addr;
  logic [RL-1:0] sreg;
  logic [CW-1:0] cnt;

  logic is_wr, bit_v, desc, addr_end, pos_last, mism, issue;

  assign is_wr    = (elem == 3'd0) || (elem >= 3'd1 && elem <= 3'd4 && pos == 2'd1);
  assign bit_v    = (elem == 3'd1 || elem == 3'd3) ? (pos != 2'd0) :
                    (elem == 3'd2 || elem == 3'd4) ? (pos == 2'd0) : 1'b0;
  assign desc     = (elem == 3'd3) || (elem == 3'd4);
  assign addr_end = desc ? (addr == '0) : (addr == '1);
  assign pos_last = (elem == 3'd0 || elem == 3'd5) ? 1'b1 : (pos == 2'd2);
  assign mism     = chk_valid && (mem_rdata != chk_exp);
  assign issue    = (st == S_RUN) && !seq_end && !(diag_q && mism);

  assign mem_en     = issue;
  assign mem_we     = issue && is_wr;
  assign mem_addr   = addr;
  assign mem_wdata  = {DW{bit_v}};
  assign meas_en    = issue && (elem >= 3'd1) && (elem <= 3'd4) && (pos == 2'd2);
  assign scan_out   = sreg[RL-1];
  assign scan_valid = (st == S_SCAN);
  assign busy       = (st == S_RUN) || (st == S_SCAN);
  assign done       = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      elem      <= '0;
      pos       <= '0;
      addr      <= '0;
      seq_end   <= 1'b0;
      diag_q    <= 1'b0;
      chk_valid <= 1'b0;
      chk_exp   <= '0;
      chk_op    <= '0;
      chk_addr  <= '0;
      sreg      <= '0;
      cnt       <= '0;
      fail      <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start) begin
          st        <= S_RUN;
          elem      <= '0;
          pos       <= '0;
          addr      <= '0;
          seq_end   <= 1'b0;
          diag_q    <= diag_mode;
          chk_valid <= 1'b0;
          fail      <= 1'b0;
        end
        S_RUN: begin
          chk_valid <= issue && !is_wr;
          if (issue && !is_wr) begin
            chk_exp  <= {DW{bit_v}};
            chk_op   <= {elem, pos};
            chk_addr <= addr;
          end
          if (mism) begin
            fail <= 1'b1;
            if (diag_q) begin
              sreg <= {chk_op, chk_addr, mem_rdata ^ chk_exp};
              cnt  <= CW'(RL - 1);
              st   <= S_SCAN;
            end
          end else if (seq_end && !chk_valid) begin
            st <= S_DONE;
          end
          if (issue) begin
            if (!pos_last) begin
              pos <= pos + 2'd1;
            end else begin
              pos <= '0;
              if (addr_end) begin
                if (elem == 3'd5) seq_end <= 1'b1;
                else begin
                  elem <= elem + 3'd1;
                  addr <= (elem == 3'd2 || elem == 3'd3) ? '1 : '0;
                end
              end else begin
                addr <= desc ? addr - 1'b1 : addr + 1'b1;
              end
            end
          end
        end
        S_SCAN: begin
          sreg <= sreg << 1;
          if (cnt == '0) st <= S_RUN;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbist_marchcp_chk.sv
module mbist_marchcp_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic mem_en,
  input logic mem_we,
  input logic meas_en,
  input logic scan_valid,
  input logic busy,
  input logic done,
  input logic fail
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !busy && !done && !fail && !scan_valid);

  assert_meas_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    meas_en |-> mem_en && !mem_we);

  assert_fail_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !(start && !busy) |=> fail);

  assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  assert_pause_on_scan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_valid |-> !mem_en);

  assert_scan_only_failing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_valid) |-> fail);
endmodule

bind mbist_marchcp mbist_marchcp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_en(mem_en), .mem_we(mem_we),
  .meas_en(meas_en), .scan_valid(scan_valid), .busy(busy), .done(done), .fail(fail)
);

// File: tb/mbist_marchcp_test.sv
module mbist_marchcp_test;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam int RL = 5 + AW + DW;

  logic clk = 0, rst_n = 0, start = 0, diag_mode = 0;
  logic mem_en, mem_we, meas_en, scan_out, scan_valid, busy, done, fail;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  mbist_marchcp #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .diag_mode(diag_mode),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .meas_en(meas_en), .scan_out(scan_out),
    .scan_valid(scan_valid), .busy(busy), .done(done), .fail(fail));

  int checks = 0, fails = 0;
  logic [DW-1:0] mem [N];
  int fa1 = -1, fa0 = -1;
  logic [DW-1:0] m1 = '0, m0 = '0;

  always @(posedge clk) if (mem_en) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    else mem_rdata <= (mem[mem_addr] | ((int'(mem_addr) == fa1) ? m1 : '0))
                      & ~((int'(mem_addr) == fa0) ? m0 : '0);
  end

  int opk, bad_ops, meas_cnt, meas_bad, busy_cyc, nrec, bitc;
  logic [RL-1:0] shreg;
  logic [RL-1:0] recs [8];

  task automatic exp_op(input int k, output logic we, output int a, output logic v);
    int e, r, p;
    if (k < N) begin e = 0; p = 0; a = k; end
    else if (k < 13*N) begin
      r = k - N; e = 1 + r / (3*N); r = r % (3*N); a = r / 3; p = r % 3;
      if (e >= 3) a = N - 1 - a;
    end else begin e = 5; p = 0; a = k - 13*N; end
    we = (e == 0) || (e >= 1 && e <= 4 && p == 1);
    v  = (e == 1 || e == 3) ? (p != 0) : (e == 2 || e == 4) ? (p == 0) : 1'b0;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (busy) busy_cyc++;
    if (mem_en) begin
      logic we, v; int a;
      exp_op(opk, we, a, v);
      if (opk >= 14*N || mem_we !== we || int'(mem_addr) != a ||
          (we && mem_wdata !== {DW{v}})) bad_ops++;
      if (meas_en) begin
        meas_cnt++;
        if (!(opk >= N && opk < 13*N && (opk - N) % 3 == 2)) meas_bad++;
      end
      opk++;
    end
    if (scan_valid) begin
      shreg = {shreg[RL-2:0], scan_out};
      bitc++;
      if (bitc == RL) begin
        if (nrec < 8) recs[nrec] = shreg;
        nrec++; bitc = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run(input bit dm);
    opk = 0; bad_ops = 0; meas_cnt = 0; meas_bad = 0; busy_cyc = 0;
    nrec = 0; bitc = 0;
    @(negedge clk); diag_mode = dm; start = 1;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
  endtask

  task automatic t_reset;
    check(!busy && !done && !fail && !mem_en && !meas_en && !scan_valid, "R1",
          "reset outputs", {busy, done, fail, mem_en, meas_en, scan_valid}, 0);
  endtask

  task automatic t_clean;
    fa1 = -1; fa0 = -1;
    run(0);
    check(bad_ops == 0 && opk == 14*N, "R2", "op order/count", opk, 14*N);
    check(bad_ops == 0, "R3", "write data and read compare", bad_ops, 0);
    check(meas_cnt == 4*N && meas_bad == 0, "R4", "meas window", meas_cnt, 4*N);
    check(!fail, "R5", "clean run fail", fail, 0);
    check(busy_cyc == 14*N + 2, "R6", "busy length", busy_cyc, 14*N + 2);
    repeat (5) @(negedge clk);
    check(done && !busy, "R6", "done held", done, 1);
  endtask

  task automatic t_normal_fault;
    fa1 = 9; m1 = 8'h10; fa0 = -1;
    run(0);
    check(fail, "R5", "fault flagged", fail, 1);
    check(nrec == 0 && bitc == 0, "R5", "no scan in normal mode", nrec, 0);
    check(bad_ops == 0 && opk == 14*N, "R2", "order under fault", opk, 14*N);
  endtask

  task automatic t_diag_sa1;
    logic [RL-1:0] e;
    fa1 = 5; m1 = 8'h04; fa0 = -1;
    run(1);
    check(fail, "R5", "diag fail", fail, 1);
    check(nrec == 5, "R7", "sa1 record count", nrec, 5);
    check(bad_ops == 0 && opk == 14*N, "R8", "resume order", opk, 14*N);
    for (int i = 0; i < 5 && i < nrec; i++) begin
      logic [2:0] el; logic [1:0] ps;
      el = 3'(i + 1); ps = (i == 1 || i == 3) ? 2'd2 : 2'd0;
      e = {el, ps, 4'd5, 8'h04};
      check(recs[i] == e, "R7", $sformatf("sa1 record %0d", i), recs[i], e);
    end
  endtask

  task automatic t_diag_sa0;
    logic [RL-1:0] e;
    fa0 = 0; m0 = 8'h80; fa1 = -1;
    run(1);
    check(nrec == 4, "R8", "sa0 record count", nrec, 4);
    check(bad_ops == 0 && opk == 14*N, "R8", "sa0 resume order", opk, 14*N);
    for (int i = 0; i < 4 && i < nrec; i++) begin
      logic [2:0] el; logic [1:0] ps;
      el = 3'(i + 1); ps = (i == 0 || i == 2) ? 2'd2 : 2'd0;
      e = {el, ps, 4'd0, 8'h80};
      check(recs[i] == e, "R7", $sformatf("sa0 record %0d", i), recs[i], e);
    end
  endtask

  task automatic t_restart;
    fa1 = -1; fa0 = -1;
    run(1);
    check(!fail, "R9", "fail cleared on restart", fail, 0);
    check(nrec == 0, "R9", "clean diag run no records", nrec, 0);
    check(busy_cyc == 14*N + 2, "R6", "busy length diag", busy_cyc, 14*N + 2);
  endtask

  initial begin
    for (int i = 0; i < N; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_normal_fault();
    t_diag_sa1();
    t_diag_sa0();
    t_restart();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule